// File: doc/BRIEF.md
# NAND Hamming Parity Accumulator

This block builds the single-error-correcting Hamming parity of a data block of up to 512 bytes on an 8-bit NAND flash bus. It watches byte strobes that carry the data byte and the chip select the byte belongs to. For each chip select it keeps a separate running parity word and a byte-position counter. A chip select's accumulator only follows traffic after software arms it through a control write. Arming also wipes the previous result. Software then streams its page through the flash interface and reads the 24-bit parity word through a small register read port. That read disarms the chip select, so later traffic leaves the stored result untouched.

The parity word has two kinds of terms. The column terms fold data bits together according to where each bit sits inside its byte. The row terms fold whole-byte parities together according to the byte's position in the block. Each term comes in an odd and an even flavour. The host compares the stored parity with the parity read back from the flash to locate a single flipped bit. That comparison is done elsewhere.

Top module: `nand_hamming_acc`

## Requirements
- R1: After reset every chip select is disarmed (`armed` reads 0) and a result read of any chip select returns 24'h000000.
- R2: A control write with bit c of `ctl_arm` set arms chip select c, and clears its parity word and its byte counter to zero. A byte strobe for c in that same cycle is discarded.
- R3: Column terms: for k in 0..2, the odd term for k is the XOR, over all accepted bytes, of the data bits whose position b (0..7) has bit k set. The even term uses the bits where bit k of b is clear.
- R4: Row terms: for j in 0..8, each accepted byte's XOR-of-bits goes into the odd term for j when bit j of its byte counter value is 1, and into the even term otherwise. The counter value is 0 for the first byte after arming.
- R5: Result layout: bits 2:0 hold the odd column terms for k=0..2, and bits 11:3 hold the odd row terms for j=0..8. Bits 23:12 hold the even terms in the same order. One byte 8'h01 at position 0 therefore gives 24'hFFF000.
- R6: A byte strobe updates only the accumulator named by `byte_cs`. Interleaving traffic across chip selects does not change any chip select's result.
- R7: A byte strobe for a chip select that is not armed changes nothing. A later read returns the previously held value.
- R8: `rd_en` with `rd_cs` makes `rd_valid` high and `rd_data` hold that chip select's parity on the cycle after the request. The value returned is the one held before any change in the request cycle. The read also disarms that chip select.
- R9: The byte counter wraps modulo 512. The 513th byte after arming is treated as byte position 0.
- R10: When an arm and a read hit the same chip select in the same cycle, the read returns the old parity and the chip select ends armed with a cleared parity word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_arm | input | 4 | Arm mask, one bit per chip select; a 1 arms, a 0 leaves alone |
| byte_vld | input | 1 | Data byte strobe |
| byte_cs | input | 2 | Chip select of the strobed byte |
| byte_data | input | 8 | Strobed data byte |
| rd_en | input | 1 | Result read request |
| rd_cs | input | 2 | Chip select to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 24 | Parity word of the requested chip select |
| armed | output | 4 | Current arm state of each chip select |

## Verification
The hardest situation to reach is a tangle of several accumulators. Two or more chip selects are armed at once while bytes for them arrive in an arbitrary interleave, and strobes for a disarmed chip select are mixed in. The bench draws that interleave from a seeded random source and keeps one model accumulator per chip select. It also drives the exact cycle where an arm and a read collide, and a run of 513 bytes that carries the byte counter past its wrap point.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned COL_W  = $clog2(DATA_W);

    function automatic int unsigned half_w(input int unsigned idx_w);
        return idx_w + COL_W;
    endfunction
endpackage

// File: rtl/hecc_byte_parity.sv
module hecc_byte_parity
    import hecc_pkg::*;
#(
    parameter int unsigned IDX_W = 9,
    localparam int unsigned HALF_W = IDX_W + COL_W,
    localparam int unsigned PAR_W  = 2 * HALF_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PAR_W-1:0]  term_o
);
    logic [COL_W-1:0] col_odd, col_even;
    logic [IDX_W-1:0] row_odd, row_even;
    logic             byte_par;

    always_comb begin
        col_odd  = '0;
        col_even = '0;
        for (int b = 0; b < int'(DATA_W); b++) begin
            for (int k = 0; k < int'(COL_W); k++) begin
                if (((b >> k) & 1) == 1) col_odd[k]  = col_odd[k]  ^ data_i[b];
                else                     col_even[k] = col_even[k] ^ data_i[b];
            end
        end
    end

    assign byte_par = ^data_i;

    generate
        for (genvar j = 0; j < int'(IDX_W); j++) begin : g_row
            assign row_odd[j]  = idx_i[j] & byte_par;
            assign row_even[j] = ~idx_i[j] & byte_par;
        end
    endgenerate

    assign term_o = {row_even, col_even, row_odd, col_odd};
endmodule

// File: rtl/hecc_lane.sv
module hecc_lane
    import hecc_pkg::*;
#(
    parameter int unsigned IDX_W = 9,
    localparam int unsigned PAR_W = 2 * (IDX_W + COL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_hit_i,
    output logic              armed_o,
    output logic [PAR_W-1:0]  parity_o
);
    typedef struct packed {
        logic             armed;
        logic [IDX_W-1:0] cnt;
        logic [PAR_W-1:0] acc;
    } lane_t;

    lane_t            st_d, st_q;
    logic [PAR_W-1:0] term;
    logic             accept;

    hecc_byte_parity #(.IDX_W(IDX_W)) i_bpar (
        .data_i (data_i),
        .idx_i  (st_q.cnt),
        .term_o (term)
    );

    assign accept = byte_i && st_q.armed && !start_i;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
            st_d.acc   = '0;
        end else begin
            if (rd_hit_i) st_d.armed = 1'b0;
            if (accept) begin
                st_d.acc = st_q.acc ^ term;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o  = st_q.armed;
    assign parity_o = st_q.acc;

    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.armed && st_q.cnt == '0 && st_q.acc == '0));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(byte_i && st_q.armed)) |=> $stable(st_q.acc) && $stable(st_q.cnt));
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.cnt == IDX_W'($past(st_q.cnt) + 1'b1));
    p_read_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && !start_i) |=> !st_q.armed);
    p_arm_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && start_i) |=> st_q.armed);
endmodule

// File: rtl/hecc_rd_port.sv
module hecc_rd_port #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned PAR_W  = 24,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en_i,
    input  logic [CS_W-1:0]              rd_cs_i,
    input  logic [NUM_CS-1:0][PAR_W-1:0] parity_i,
    output logic                         rd_valid_o,
    output logic [PAR_W-1:0]             rd_data_o
);
    typedef struct packed {
        logic             valid;
        logic [PAR_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en_i;
        rd_d.data  = rd_q.data;
        if (rd_en_i) rd_d.data = parity_i[rd_cs_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

    p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);
    p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o && $stable(rd_data_o));
endmodule

// File: rtl/nand_hamming_acc.sv
module nand_hamming_acc
    import hecc_pkg::*;
#(
    parameter int unsigned NUM_CS      = 4,
    parameter int unsigned BLOCK_BYTES = 512,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned IDX_W = $clog2(BLOCK_BYTES),
    localparam int unsigned PAR_W = 2 * (IDX_W + COL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [NUM_CS-1:0] ctl_arm,
    input  logic              byte_vld,
    input  logic [CS_W-1:0]   byte_cs,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_en,
    input  logic [CS_W-1:0]   rd_cs,
    output logic              rd_valid,
    output logic [PAR_W-1:0]  rd_data,
    output logic [NUM_CS-1:0] armed
);
    logic [NUM_CS-1:0][PAR_W-1:0] lane_par;

    generate
        for (genvar c = 0; c < int'(NUM_CS); c++) begin : g_lane
            logic lane_start, lane_byte, lane_rd;
            assign lane_start = ctl_wr && ctl_arm[c];
            assign lane_byte  = byte_vld && (byte_cs == CS_W'(c));
            assign lane_rd    = rd_en && (rd_cs == CS_W'(c));

            hecc_lane #(.IDX_W(IDX_W)) i_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .start_i  (lane_start),
                .byte_i   (lane_byte),
                .data_i   (byte_data),
                .rd_hit_i (lane_rd),
                .armed_o  (armed[c]),
                .parity_o (lane_par[c])
            );

            p_other_cs_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (byte_vld && byte_cs != CS_W'(c) && !lane_start) |=> $stable(lane_par[c]));
        end
    endgenerate

    hecc_rd_port #(.NUM_CS(NUM_CS), .PAR_W(PAR_W)) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .rd_cs_i    (rd_cs),
        .parity_i   (lane_par),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );
endmodule

// File: tb/test_nand_hamming_acc.sv
module test_nand_hamming_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_arm = '0;
    logic        byte_vld = 1'b0;
    logic [1:0]  byte_cs = '0;
    logic [7:0]  byte_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_cs = '0;
    logic        rd_valid;
    logic [23:0] rd_data;
    logic [3:0]  armed;

    int errors = 0;
    int checks = 0;

    logic [23:0] m_acc [4];
    int          m_cnt [4];
    logic [3:0]  m_arm;

    always #2.5 clk = ~clk;

    nand_hamming_acc i_nand_hamming_acc (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_arm(ctl_arm),
        .byte_vld(byte_vld), .byte_cs(byte_cs), .byte_data(byte_data),
        .rd_en(rd_en), .rd_cs(rd_cs), .rd_valid(rd_valid), .rd_data(rd_data),
        .armed(armed)
    );

    function automatic logic [23:0] contrib(input int idx, input logic [7:0] d);
        logic [23:0] r = '0;
        logic        bp = 1'b0;
        for (int b = 0; b < 8; b++) begin
            bp = bp ^ d[b];
            for (int k = 0; k < 3; k++) begin
                if ((b & (1 << k)) != 0) r[k]      = r[k]      ^ d[b];
                else                     r[12 + k] = r[12 + k] ^ d[b];
            end
        end
        for (int j = 0; j < 9; j++) begin
            if ((idx & (1 << j)) != 0) r[3 + j]  = r[3 + j]  ^ bp;
            else                       r[15 + j] = r[15 + j] ^ bp;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] smask, input logic bv, input logic [1:0] bcs,
                        input logic [7:0] bd, input logic re, input logic [1:0] rcs,
                        input string tag);
        logic [23:0] exp;
        @(negedge clk);
        ctl_wr = (smask != 0); ctl_arm = smask;
        byte_vld = bv; byte_cs = bcs; byte_data = bd;
        rd_en = re; rd_cs = rcs;
        exp = m_acc[rcs];
        if (bv && m_arm[bcs] && !smask[bcs]) begin
            m_acc[bcs] = m_acc[bcs] ^ contrib(m_cnt[bcs], bd);
            m_cnt[bcs] = (m_cnt[bcs] + 1) % 512;
        end
        for (int c = 0; c < 4; c++) begin
            if (smask[c]) begin
                m_arm[c] = 1'b1; m_acc[c] = '0; m_cnt[c] = 0;
            end else if (re && rcs == 2'(c)) begin
                m_arm[c] = 1'b0;
            end
        end
        @(negedge clk);
        ctl_wr = 1'b0; ctl_arm = '0; byte_vld = 1'b0; rd_en = 1'b0;
        if (re) begin
            check({tag, " rd_valid"}, {23'd0, rd_valid}, 24'd1);
            check(tag, rd_data, exp);
        end
    endtask

    task automatic check_armed(input string tag);
        check({tag, " armed"}, {20'd0, armed}, {20'd0, m_arm});
    endtask

    task automatic arm(input logic [3:0] m);
        step(m, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, "R2");
    endtask

    task automatic send(input logic [1:0] cs, input logic [7:0] d);
        step(4'h0, 1'b1, cs, d, 1'b0, 2'd0, "byte");
    endtask

    task automatic rd(input logic [1:0] cs, input string tag);
        step(4'h0, 1'b0, 2'd0, 8'h00, 1'b1, cs, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 4; c++) begin m_acc[c] = '0; m_cnt[c] = 0; end
        m_arm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_armed("R1");
        for (int c = 0; c < 4; c++) rd(2'(c), "R1 reset read");

        // R5 literal layout, R2 arm
        arm(4'b0010);
        check_armed("R2");
        send(2'd1, 8'h01);
        rd(2'd1, "R5 single byte");
        check("R5 literal", m_acc[1], 24'hFFF000);
        check_armed("R8 disarm");

        // R3 R4 full random page on cs0
        arm(4'b0001);
        for (int i = 0; i < 512; i++) send(2'd0, 8'($urandom));
        rd(2'd0, "R3 R4 page cs0");
        check_armed("R8");

        // R7 unarmed cs0 ignores traffic, read keeps old value
        for (int i = 0; i < 20; i++) send(2'd0, 8'($urandom));
        rd(2'd0, "R7 unarmed hold");

        // R6 interleaved cs2/cs3 with noise on disarmed cs0
        arm(4'b1100);
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 5);
            if (r < 2)      send(2'd2, 8'($urandom));
            else if (r < 4) send(2'd3, 8'($urandom));
            else            send(2'd0, 8'($urandom));
        end
        rd(2'd2, "R6 interleave cs2");
        rd(2'd3, "R6 interleave cs3");
        rd(2'd0, "R7 noise cs0");

        // R9 wrap at 513 bytes
        arm(4'b0010);
        for (int i = 0; i < 513; i++) send(2'd1, 8'($urandom));
        rd(2'd1, "R9 wrap");

        // R2 re-arm mid stream clears
        arm(4'b0100);
        for (int i = 0; i < 7; i++) send(2'd2, 8'($urandom));
        arm(4'b0100);
        send(2'd2, 8'hA5);
        rd(2'd2, "R2 rearm");

        // R2 byte in arm cycle discarded
        step(4'b1000, 1'b1, 2'd3, 8'hFF, 1'b0, 2'd0, "R2 arm+byte");
        rd(2'd3, "R2 byte at arm");

        // R10 arm and read collide
        arm(4'b0001);
        for (int i = 0; i < 5; i++) send(2'd0, 8'($urandom));
        step(4'b0001, 1'b0, 2'd0, 8'h00, 1'b1, 2'd0, "R10 old value");
        check_armed("R10");
        rd(2'd0, "R10 cleared");

        // several random lengths, random lanes
        for (int t = 0; t < 6; t++) begin
            logic [1:0] cs = 2'($urandom % 4);
            int n = int'($urandom % 512) + 1;
            arm(4'(1 << cs));
            for (int i = 0; i < n; i++) send(cs, 8'($urandom));
            rd(cs, "R3 R4 random length");
        end
        check_armed("R8 final");

        finish_run();
    end
endmodule